// File: doc/BRIEF.md
# Stack Pointer and Stack Transfer Engine

This block owns an 8-bit stack pointer and a private byte-wide stack RAM. It carries out single-byte push and pop requests, and it saves or restores a 16-bit return address for subroutine calls, interrupt entry, subroutine return and interrupt return. A push advances the pointer first and then stores at the new location. A pop reads at the current location and then steps the pointer back. The pointer comes out of reset at 07h, so the first byte saved after reset goes to location 08h.

A sequencer drives the RAM one transfer per cycle and reports `busy` while a request is in progress. It pulses `done` when the request finishes. Restored bytes appear on `pop_data` or `ret_addr`. The RAM access bus (`mem_addr`, `mem_wdata`, `mem_we`) is brought out so the transfers can be observed; a write presented on it takes effect at the next clock edge. A register port loads or reads the pointer directly. A load attempted during a transfer is rejected and flagged.

Top module: `stack_engine`

## Requirements
- R1: After a synchronous reset the state is: `sp_rdata` = 07h, `busy` = 0, `done` = 0, `irq_release` = 0, `sp_wr_refused` = 0.
- R2: A push (`cmd_op` = 0) accepted while idle presents `mem_we` = 1, `mem_addr` = pointer+1 and `mem_wdata` = `cmd_byte` in the next cycle. The pointer then becomes pointer+1, so the first push after reset writes address 08h.
- R3: A pop (`cmd_op` = 1) reads the byte at the current pointer, steps the pointer down by one, and presents the byte on `pop_data` in the cycle that `done` is high.
- R4: A call (`cmd_op` = 2) or an interrupt entry (`cmd_op` = 3) writes `cmd_raddr[7:0]` at pointer+1 and then `cmd_raddr[15:8]` at pointer+2, in two consecutive cycles, and leaves the pointer two higher.
- R5: A return (`cmd_op` = 4) reads the high byte at the pointer and then the low byte at pointer-1. It leaves the pointer two lower and presents the reassembled address on `ret_addr` while `done` is high.
- R6: An interrupt return (`cmd_op` = 5) behaves like a return and raises `irq_release` for exactly the cycle that `done` is high. A plain return leaves `irq_release` low.
- R7: Pointer arithmetic wraps modulo 256. A push at pointer FFh writes address 00h, and a pop at pointer 00h leaves the pointer at FFh.
- R8: `sp_wr` asserted while idle loads `sp_wdata` into the pointer, and the new value is visible on `sp_rdata` in the next cycle.
- R9: `sp_wr` asserted while `busy` is high leaves the pointer untouched by the load and raises `sp_wr_refused` for one cycle in the following cycle.
- R10: A request on `cmd_valid` while `busy` is high is ignored: it causes no RAM write and no pointer change.
- R11: `busy` stays high for 1 cycle for a push, 2 for a pop, call or interrupt entry, and 3 for either return. `done` is then a single-cycle pulse with `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Request strobe, taken when idle |
| cmd_op | input | 3 | 0 push, 1 pop, 2 call, 3 interrupt entry, 4 return, 5 interrupt return |
| cmd_byte | input | 8 | Byte to push |
| cmd_raddr | input | 16 | Return address to save on call or interrupt entry |
| sp_wr | input | 1 | Direct pointer load strobe |
| sp_wdata | input | 8 | Value for direct pointer load |
| sp_rdata | output | 8 | Current pointer value |
| sp_wr_refused | output | 1 | Pulse: a load was rejected while busy |
| busy | output | 1 | A stack request is in progress |
| done | output | 1 | Pulse: request finished |
| pop_data | output | 8 | Byte restored by the last pop |
| ret_addr | output | 16 | Address restored by the last return |
| irq_release | output | 1 | Pulse with done on interrupt return |
| mem_addr | output | 8 | Stack RAM address of the current access |
| mem_wdata | output | 8 | Stack RAM write data |
| mem_we | output | 1 | Stack RAM write enable |

## Verification
Single-byte pushes and pops are interleaved with different values to show that the pre-increment write and the post-decrement read are ordered correctly: pushing two bytes and popping one must return the second byte. Calls paired with returns, and interrupt entries paired with interrupt returns, use addresses whose two halves differ, so a swapped byte order shows up in `ret_addr`. Only the interrupt pair may release the interrupt level. A pointer loaded to FEh is driven through the FFh/00h boundary in both directions to expose missing wrap. Loads and new requests injected during a call show whether the busy guard holds.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_CALL = 3'd2,
    OP_INTR = 3'd3,
    OP_RET  = 3'd4,
    OP_RETI = 3'd5
  } stk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_LO,
    ST_WR_HI,
    ST_RD_HI,
    ST_RD_LO,
    ST_RD_END
  } stk_st_e;
endpackage

// File: rtl/stk_ram.sv
module stk_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int          AW     = 8,
  parameter logic [AW-1:0] RST_VAL = 8'h07
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  input  logic          dec,
  output logic [AW-1:0] sp
);
  localparam logic [AW-1:0] ONE = 1;

  always_ff @(posedge clk) begin
    if (rst)       sp <= RST_VAL;
    else if (load) sp <= load_val;
    else if (inc)  sp <= sp + ONE;
    else if (dec)  sp <= sp - ONE;
  end

  AST_NO_INC_DEC: assert property (@(posedge clk) disable iff (rst)
    !(inc && dec)) else $error("inc and dec together"); // R7
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [DW-1:0]   cmd_byte,
  input  logic [2*DW-1:0] cmd_raddr,
  input  logic [AW-1:0]   sp,
  input  logic [DW-1:0]   rdata,
  output logic            busy,
  output logic            inc,
  output logic            dec,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_we,
  output logic [DW-1:0]   mem_wdata,
  output logic            done,
  output logic [DW-1:0]   pop_data,
  output logic [2*DW-1:0] ret_addr,
  output logic            irq_release
);
  localparam logic [AW-1:0] ONE = 1;

  stk_st_e          state;
  stk_op_e          op_q;
  logic [DW-1:0]    byte_q;
  logic [2*DW-1:0]  raddr_q;
  logic [DW-1:0]    hi_q;

  always_comb begin
    busy      = (state != ST_IDLE);
    mem_we    = (state == ST_WR_LO) || (state == ST_WR_HI);
    inc       = mem_we;
    dec       = (state == ST_RD_HI) || (state == ST_RD_LO);
    mem_addr  = mem_we ? sp + ONE : sp;
    if (state == ST_WR_HI)    mem_wdata = raddr_q[2*DW-1:DW];
    else if (op_q == OP_PUSH) mem_wdata = byte_q;
    else                      mem_wdata = raddr_q[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      op_q        <= OP_PUSH;
      byte_q      <= '0;
      raddr_q     <= '0;
      hi_q        <= '0;
      done        <= 1'b0;
      pop_data    <= '0;
      ret_addr    <= '0;
      irq_release <= 1'b0;
    end else begin
      done        <= 1'b0;
      irq_release <= 1'b0;
      case (state)
        ST_IDLE: if (cmd_valid) begin
          op_q    <= stk_op_e'(cmd_op);
          byte_q  <= cmd_byte;
          raddr_q <= cmd_raddr;
          case (stk_op_e'(cmd_op))
            OP_PUSH, OP_CALL, OP_INTR: state <= ST_WR_LO;
            OP_POP:                    state <= ST_RD_LO;
            OP_RET, OP_RETI:           state <= ST_RD_HI;
            default:                   state <= ST_IDLE;
          endcase
        end
        ST_WR_LO: begin
          if (op_q == OP_PUSH) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state <= ST_WR_HI;
          end
        end
        ST_WR_HI: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        ST_RD_HI: state <= ST_RD_LO;
        ST_RD_LO: begin
          if (op_q != OP_POP) hi_q <= rdata;
          state <= ST_RD_END;
        end
        ST_RD_END: begin
          done <= 1'b1;
          if (op_q == OP_POP) pop_data <= rdata;
          else begin
            ret_addr    <= {hi_q, rdata};
            irq_release <= (op_q == OP_RETI);
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy) else $error("done while busy"); // R11
  AST_REL_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    irq_release |-> done) else $error("release without done"); // R6
  AST_WR_MOVES_SP: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> sp == $past(mem_addr)) else $error("pointer not at written address"); // R2
endmodule

// File: rtl/stack_engine.sv
module stack_engine
  import stk_pkg::*;
#(
  parameter int            AW      = 8,
  parameter int            DW      = 8,
  parameter logic [AW-1:0] SP_INIT = 8'h07
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [DW-1:0]   cmd_byte,
  input  logic [2*DW-1:0] cmd_raddr,
  input  logic            sp_wr,
  input  logic [AW-1:0]   sp_wdata,
  output logic [AW-1:0]   sp_rdata,
  output logic            sp_wr_refused,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   pop_data,
  output logic [2*DW-1:0] ret_addr,
  output logic            irq_release,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we
);
  localparam logic [AW-1:0] ONE = 1;

  logic          sp_load, sp_inc, sp_dec;
  logic [AW-1:0] sp_q;
  logic [DW-1:0] ram_rdata;

  assign sp_load  = sp_wr && !busy;
  assign sp_rdata = sp_q;

  always_ff @(posedge clk) begin
    if (rst) sp_wr_refused <= 1'b0;
    else     sp_wr_refused <= sp_wr && busy;
  end

  stk_ptr #(.AW(AW), .RST_VAL(SP_INIT)) u_ptr (
    .clk(clk), .rst(rst), .load(sp_load), .load_val(sp_wdata),
    .inc(sp_inc), .dec(sp_dec), .sp(sp_q)
  );

  stk_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .cmd_raddr(cmd_raddr), .sp(sp_q), .rdata(ram_rdata),
    .busy(busy), .inc(sp_inc), .dec(sp_dec), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .done(done), .pop_data(pop_data),
    .ret_addr(ret_addr), .irq_release(irq_release)
  );

  stk_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .addr(mem_addr), .we(mem_we), .wdata(mem_wdata), .rdata(ram_rdata)
  );

  AST_SP_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(sp_load) |-> (sp_q == $past(sp_q) || sp_q == $past(sp_q) + ONE ||
                         sp_q == $past(sp_q) - ONE)) else $error("pointer jumped"); // R7
  AST_REFUSE_BUSY: assert property (@(posedge clk) disable iff (rst)
    sp_wr_refused |-> $past(busy)) else $error("refusal while idle"); // R9
  AST_WE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !$past(busy)) |-> $past(cmd_valid)) else $error("write without request"); // R10
endmodule

// File: tb/test_stack_engine.sv
module test_stack_engine;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [7:0]  cmd_byte;
  logic [15:0] cmd_raddr;
  logic        sp_wr;
  logic [7:0]  sp_wdata;
  logic [7:0]  sp_rdata, pop_data, mem_addr, mem_wdata;
  logic        sp_wr_refused, busy, done, irq_release, mem_we;
  logic [15:0] ret_addr;

  int n_cmp = 0;
  int n_bad = 0;
  int m_sp;
  logic [7:0] m_mem [256];

  always #4 clk = ~clk;

  stack_engine i_stack_engine (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .cmd_raddr(cmd_raddr), .sp_wr(sp_wr), .sp_wdata(sp_wdata),
    .sp_rdata(sp_rdata), .sp_wr_refused(sp_wr_refused), .busy(busy), .done(done),
    .pop_data(pop_data), .ret_addr(ret_addr), .irq_release(irq_release),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(int op, int b, int a);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_byte = 8'(b); cmd_raddr = 16'(a);
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic do_push(int b);
    issue(0, b, 0);
    chk("R2", "push we", int'(mem_we), 1);
    chk("R2", "push addr", int'(mem_addr), (m_sp + 1) % 256);
    chk("R2", "push data", int'(mem_wdata), b);
    chk("R11", "push busy", int'(busy), 1);
    step();
    m_sp = (m_sp + 1) % 256;
    m_mem[m_sp] = 8'(b);
    chk("R2", "push sp", int'(sp_rdata), m_sp);
    chk("R11", "push done", int'(done), 1);
    chk("R11", "push idle", int'(busy), 0);
  endtask

  task automatic do_pop();
    int exp_b;
    exp_b = int'(m_mem[m_sp]);
    issue(1, 0, 0);
    chk("R3", "pop addr", int'(mem_addr), m_sp);
    chk("R3", "pop no write", int'(mem_we), 0);
    step();
    m_sp = (m_sp + 255) % 256;
    chk("R3", "pop sp", int'(sp_rdata), m_sp);
    chk("R11", "pop busy", int'(busy), 1);
    step();
    chk("R3", "pop data", int'(pop_data), exp_b);
    chk("R11", "pop done", int'(done), 1);
    chk("R11", "pop idle", int'(busy), 0);
  endtask

  task automatic do_call(int op, int a, bit meddle);
    int sp0;
    sp0 = m_sp;
    issue(op, 0, a);
    chk("R4", "lo we", int'(mem_we), 1);
    chk("R4", "lo addr", int'(mem_addr), (m_sp + 1) % 256);
    chk("R4", "lo data", int'(mem_wdata), a & 255);
    if (meddle) begin
      sp_wr = 1'b1; sp_wdata = 8'h55;
      cmd_valid = 1'b1; cmd_op = 3'd0; cmd_byte = 8'h99;
    end
    step();
    sp_wr = 1'b0; cmd_valid = 1'b0;
    m_sp = (m_sp + 1) % 256;
    m_mem[m_sp] = 8'(a);
    if (meddle) chk("R9", "refused pulse", int'(sp_wr_refused), 1);
    chk("R4", "hi addr", int'(mem_addr), (m_sp + 1) % 256);
    chk("R4", "hi data", int'(mem_wdata), (a >> 8) & 255);
    chk("R11", "call busy", int'(busy), 1);
    step();
    m_sp = (m_sp + 1) % 256;
    m_mem[m_sp] = 8'(a >> 8);
    chk("R4", "call sp", int'(sp_rdata), (sp0 + 2) % 256);
    chk("R11", "call done", int'(done), 1);
    if (meddle) begin
      chk("R9", "refused once", int'(sp_wr_refused), 0);
      step();
      chk("R10", "ignored push no write", int'(mem_we), 0);
      chk("R10", "ignored push sp", int'(sp_rdata), m_sp);
      chk("R10", "ignored push idle", int'(busy), 0);
    end
  endtask

  task automatic do_ret(bit reti);
    int exp_a;
    exp_a = int'(m_mem[m_sp]) * 256 + int'(m_mem[(m_sp + 255) % 256]);
    issue(reti ? 5 : 4, 0, 0);
    chk("R5", "hi addr", int'(mem_addr), m_sp);
    step();
    m_sp = (m_sp + 255) % 256;
    chk("R5", "lo addr", int'(mem_addr), m_sp);
    chk("R5", "sp-1", int'(sp_rdata), m_sp);
    step();
    m_sp = (m_sp + 255) % 256;
    chk("R5", "sp-2", int'(sp_rdata), m_sp);
    chk("R11", "ret busy", int'(busy), 1);
    chk("R6", "no early release", int'(irq_release), 0);
    step();
    chk("R5", "ret addr", int'(ret_addr), exp_a);
    chk("R11", "ret done", int'(done), 1);
    chk("R6", "release", int'(irq_release), reti ? 1 : 0);
    step();
    chk("R6", "release one cycle", int'(irq_release), 0);
    chk("R11", "done one cycle", int'(done), 0);
  endtask

  task automatic do_load(int v);
    sp_wr = 1'b1; sp_wdata = 8'(v);
    step();
    sp_wr = 1'b0;
    m_sp = v;
    chk("R8", "load sp", int'(sp_rdata), v);
    chk("R9", "no refusal when idle", int'(sp_wr_refused), 0);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_byte = '0; cmd_raddr = '0;
    sp_wr = 1'b0; sp_wdata = '0;
    @(negedge clk);
    step(); step();
    rst = 1'b0;
    m_sp = 7;
    chk("R1", "reset sp", int'(sp_rdata), 7);
    chk("R1", "reset busy", int'(busy), 0);
    chk("R1", "reset done", int'(done), 0);
    chk("R1", "reset release", int'(irq_release), 0);
    chk("R1", "reset refused", int'(sp_wr_refused), 0);
    do_push(8'hA5);
    chk("R2", "first push landed at 08", m_sp, 8);
    do_push(8'h3C);
    do_pop();
    do_call(2, 16'h1234, 1'b0);
    do_ret(1'b0);
    do_call(3, 16'hBEEF, 1'b1);
    do_ret(1'b1);
    do_pop();
    do_load(8'hFE);
    do_push(8'h11);
    do_push(8'h22);
    chk("R7", "wrapped to 00", int'(sp_rdata), 0);
    do_pop();
    do_pop();
    chk("R7", "pop wrapped to FE", int'(sp_rdata), 8'hFE);
    do_load(8'hFF);
    do_call(2, 16'hC3A7, 1'b0);
    do_ret(1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule